// File: doc/BRIEF.md
# Register-Driven Two-Wire Bus Master

This block lets system software run single-byte transfers on an open-drain two-wire bus (one clock line, one data line). Software sees one 32-bit register word made of four byte lanes. It loads a target word address and, for a write, an outgoing data byte. It then writes the slave-address byte, and that write launches the transfer. The block can run three kinds of transfer: a byte write, a random byte read (word address first, then a repeated START and the read), and a quick command. A quick command sends only the address byte with its read/write bit.

Software polls a busy flag in the control byte until it clears, then checks an error flag. After a read that ends without error, the received byte is in the data lane. A separate engine that loads from a ROM at power-up reports its activity through an input. While that input is high, no new transfer may start. The bus clock is a fixed fraction of the system clock: each quarter of a bus-clock period lasts `QDIV` system cycles.

Top module: `twi_sw_master`

## Requirements
- R1: The read word `reg_rdata` is laid out as follows. Bits 7:0 hold the data byte and bits 15:8 the word address. Bits 23:16 hold the slave byte: bits 23:17 are the 7-bit slave address and bit 16 is the direction, 1 = read. Bits 31:24 are control: bit 31 quick-command select, bit 30 test bit, bit 29 the `rom_busy` input, bit 28 the `bus_ok` input, bits 27:26 zero, bit 25 error, bit 24 busy. A write updates only the lanes whose `reg_be` bit is set. Only bits 31 and 30 of the control lane are writable.
- R2: A write whose lane mask includes lane 2 starts a transfer, and busy reads 1 from the next cycle. A write that does not touch lane 2 only loads values and starts nothing.
- R3: While busy is 1, every register write is ignored. While `rom_busy` is 1, a write to lane 2 starts no transfer.
- R4: With quick select 0 and direction 0, the bus carries START, the slave byte with bit 0 cleared, the word address, the data byte, then STOP. Each byte is sent most significant bit first and is followed by an acknowledge bit.
- R5: With quick select 0 and direction 1, the bus carries START, the slave byte with bit 0 cleared, the word address, a repeated START, the slave byte with bit 0 set, then eight bits from the slave. The master answers the received byte with a not-acknowledge (SDA released) and sends STOP. The received byte replaces the data lane.
- R6: With quick select 1, the bus carries START, the slave byte with its direction bit as loaded, then STOP. The word address is not sent and the data lane is left unchanged.
- R7: A missing acknowledge on any byte the master sends sets the error flag. The block then sends STOP at once and clears busy. The error flag reads 0 from the cycle after the next transfer starts.
- R8: Every bus quarter lasts `QDIV` cycles, so SCL stays high for 2·`QDIV` cycles per bit. A transfer keeps busy high for `QDIV`·(8 + 36·B + 4·S) cycles, where B is the number of bytes on the bus and S is 1 when a repeated START occurs. SDA changes while SCL is high only to form START or STOP.
- R9: After reset, all registers are zero and neither line is pulled. Whenever busy is 0, both lines are released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_be | input | 4 | Byte-lane enables for the write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Register read word |
| rom_busy | input | 1 | ROM load engine active; blocks new transfers |
| bus_ok | input | 1 | Serial bus present/enabled indication |
| scl_pull | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_pull | output | 1 | 1 pulls SDA low, 0 releases it |
| sda_in | input | 1 | Sampled level of SDA |

## Verification
The assertions check on every cycle that both lines stay released while idle and that a write accepted on lane 2 raises busy and clears the error flag. They also check that register writes during a transfer leave the word address unchanged, that a quick command never alters the data lane, and that SDA holds still while SCL is high inside a data or acknowledge bit. The bench's bus slave model is needed for everything that depends on the order of bus events. That covers which bytes arrive and in which sequence, whether a repeated START appears, the master's final not-acknowledge, and the byte captured from the slave. It also covers how an injected not-acknowledge at each byte position cuts the transfer short and changes the total busy time.

// File: rtl/twi_sw_master.sv
module twi_sw_master #(
  parameter int QDIV = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [3:0]  reg_be,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        rom_busy,
  input  logic        bus_ok,
  output logic        scl_pull,
  output logic        sda_pull,
  input  logic        sda_in
);
  localparam int DW = (QDIV > 1) ? $clog2(QDIV) : 1;
  localparam logic [DW-1:0] DRELOAD = DW'(QDIV - 1);

  typedef enum logic [1:0] {SG_START, SG_TX, SG_RX, SG_STOP} seg_e;

  logic [7:0]    data_q, word_q, sadr_q, tx_byte;
  logic          quick_q, test_q, busy_q, err_q, ack_bad;
  logic [2:0]    ph;
  logic [3:0]    bitc;
  logic [1:0]    qtr;
  logic [DW-1:0] divc;
  logic          scl_lo, sda_lo;
  seg_e          seg;
  logic          load, start, tick, rd;
  logic          unused_bits;

  assign load  = reg_we && !busy_q;
  assign start = load && reg_be[2] && !rom_busy;
  assign tick  = busy_q && (divc == '0);
  assign rd    = sadr_q[0];

  assign scl_pull    = scl_lo;
  assign sda_pull    = sda_lo;
  assign reg_rdata   = {quick_q, test_q, rom_busy, bus_ok, 2'b00, err_q, busy_q,
                        sadr_q, word_q, data_q};
  assign unused_bits = ^reg_wdata[29:24];

  always_comb begin
    if (quick_q)
      seg = (ph == 3'd0) ? SG_START : (ph == 3'd1) ? SG_TX : SG_STOP;
    else if (!rd)
      seg = (ph == 3'd0) ? SG_START : (ph <= 3'd3) ? SG_TX : SG_STOP;
    else begin
      case (ph)
        3'd0, 3'd3:       seg = SG_START;
        3'd1, 3'd2, 3'd4: seg = SG_TX;
        3'd5:             seg = SG_RX;
        default:          seg = SG_STOP;
      endcase
    end
  end

  always_comb begin
    case (ph)
      3'd1:    tx_byte = {sadr_q[7:1], quick_q ? rd : 1'b0};
      3'd2:    tx_byte = word_q;
      3'd3:    tx_byte = data_q;
      default: tx_byte = {sadr_q[7:1], 1'b1};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      word_q  <= '0;
      sadr_q  <= '0;
      quick_q <= 1'b0;
      test_q  <= 1'b0;
      busy_q  <= 1'b0;
      err_q   <= 1'b0;
      ack_bad <= 1'b0;
      ph      <= '0;
      bitc    <= '0;
      qtr     <= '0;
      divc    <= '0;
      scl_lo  <= 1'b0;
      sda_lo  <= 1'b0;
    end else begin
      if (load) begin
        if (reg_be[0]) data_q <= reg_wdata[7:0];
        if (reg_be[1]) word_q <= reg_wdata[15:8];
        if (reg_be[2]) sadr_q <= reg_wdata[23:16];
        if (reg_be[3]) begin
          quick_q <= reg_wdata[31];
          test_q  <= reg_wdata[30];
        end
      end
      if (start) begin
        busy_q  <= 1'b1;
        err_q   <= 1'b0;
        ack_bad <= 1'b0;
        ph      <= '0;
        bitc    <= '0;
        qtr     <= '0;
        divc    <= DRELOAD;
      end else if (busy_q) begin
        divc <= tick ? DRELOAD : divc - DW'(1);
        if (tick) begin
          qtr <= qtr + 2'd1;
          case (qtr)
            2'd0: begin
              scl_lo <= 1'b1;
              case (seg)
                SG_START: sda_lo <= 1'b0;
                SG_TX:    sda_lo <= (bitc < 4'd8) ? ~tx_byte[~bitc[2:0]] : 1'b0;
                SG_RX:    sda_lo <= 1'b0;
                default:  sda_lo <= 1'b1;
              endcase
            end
            2'd1: scl_lo <= 1'b0;
            2'd2: begin
              case (seg)
                SG_START: sda_lo <= 1'b1;
                SG_TX:    if (bitc == 4'd8) ack_bad <= sda_in;
                SG_RX:    if (bitc < 4'd8) data_q <= {data_q[6:0], sda_in};
                default:  sda_lo <= 1'b0;
              endcase
            end
            default: begin
              if (seg == SG_STOP) begin
                busy_q <= 1'b0;
              end else begin
                scl_lo <= 1'b1;
                if (seg == SG_START) begin
                  ph <= ph + 3'd1;
                end else if (bitc == 4'd8) begin
                  bitc <= '0;
                  if (seg == SG_TX && ack_bad) begin
                    err_q <= 1'b1;
                    ph    <= 3'd7;
                  end else begin
                    ph <= ph + 3'd1;
                  end
                end else begin
                  bitc <= bitc + 4'd1;
                end
              end
            end
          endcase
        end
      end
    end
  end

  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_be[2] && !busy_q && !rom_busy) |=> busy_q);

  p_err_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_be[2] && !busy_q && !rom_busy) |=> !err_q);

  p_hold_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && reg_we) |=> $stable(word_q));

  p_quick_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && quick_q) |=> $stable(data_q));

  p_idle_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> (!scl_pull && !sda_pull));

  p_sda_steady_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && (seg == SG_TX || seg == SG_RX) && !scl_pull && $past(!scl_pull))
      |-> $stable(sda_pull));
endmodule

// File: tb/sim_twi_sw_master.sv
module sim_twi_sw_master;
  localparam int CLK_P = 10;
  localparam int QD    = 4;

  typedef struct packed {
    logic       q;
    logic       r;
    logic [6:0] a;
    logic [7:0] w;
    logic [7:0] d;
    logic [7:0] s;
    logic [3:0] nk;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VT [NV] = '{
    '{1'b0, 1'b0, 7'h50, 8'h12, 8'hA5, 8'h00, 4'hF},
    '{1'b0, 1'b1, 7'h50, 8'h34, 8'h00, 8'h3C, 4'hF},
    '{1'b1, 1'b0, 7'h2A, 8'h77, 8'h99, 8'h00, 4'hF},
    '{1'b1, 1'b1, 7'h11, 8'h55, 8'h66, 8'hFF, 4'hF},
    '{1'b0, 1'b0, 7'h23, 8'h01, 8'h02, 8'h00, 4'h0},
    '{1'b0, 1'b1, 7'h23, 8'h45, 8'hC3, 8'h00, 4'h1},
    '{1'b0, 1'b0, 7'h68, 8'h9A, 8'hBC, 8'h00, 4'h2},
    '{1'b0, 1'b1, 7'h68, 8'hDE, 8'hF0, 8'h81, 4'h2},
    '{1'b0, 1'b1, 7'h7F, 8'h00, 8'h11, 8'hFF, 4'hF},
    '{1'b0, 1'b1, 7'h01, 8'hFF, 8'hEE, 8'h00, 4'hF},
    '{1'b1, 1'b0, 7'h3B, 8'h00, 8'h00, 8'h00, 4'h0},
    '{1'b0, 1'b0, 7'h7F, 8'hFF, 8'h00, 8'h00, 4'hF}
  };

  logic        clk = 1'b0, rst_n = 1'b0, we = 1'b0;
  logic [3:0]  be = '0;
  logic [31:0] wd = '0;
  logic [31:0] rd;
  logic        romb = 1'b0, bok = 1'b1;
  logic        scl_pull, sda_pull, sl_drv = 1'b0;
  logic        scl, sda;
  int          nchk = 0, nerr = 0;

  assign scl = ~scl_pull;
  assign sda = ~(sda_pull | sl_drv);

  twi_sw_master #(.QDIV(QD)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(we), .reg_be(be), .reg_wdata(wd),
    .reg_rdata(rd), .rom_busy(romb), .bus_ok(bok),
    .scl_pull(scl_pull), .sda_pull(sda_pull), .sda_in(sda)
  );

  always #(CLK_P/2) clk = ~clk;

  int         pulse = 0, nstart = 0, nstop = 0, nlog = 0, fidx = 0, nack_at = 99, bi = 0;
  logic [7:0] lg [8];
  logic [7:0] sh = '0, srd = '0;
  logic       reading = 1'b0, rd_next = 1'b0, mack = 1'b0, ackv;
  longint     cyc = 0, t_rise = 0, hi_w = 0;

  always @(posedge clk) cyc++;

  always @(negedge sda) if (scl === 1'b1) begin
    nstart++; pulse = 0; reading = 1'b0; rd_next = 1'b0; fidx = 0; sl_drv = 1'b0;
  end

  always @(posedge sda) if (scl === 1'b1) begin
    nstop++; reading = 1'b0;
  end

  always @(posedge scl) begin
    t_rise = cyc;
    if (pulse % 9 < 8 && !reading) sh = {sh[6:0], sda};
    if (pulse % 9 == 8 && reading) mack = sda;
    pulse++;
  end

  always @(negedge scl) begin
    hi_w = cyc - t_rise;
    bi = pulse % 9;
    if (bi == 8) begin
      if (!reading) begin
        if (nlog < 8) lg[nlog] = sh;
        ackv = (nlog != nack_at);
        if (fidx == 0 && sh[0] && ackv) rd_next = 1'b1;
        nlog++; fidx++;
        sl_drv = ackv;
      end else sl_drv = 1'b0;
    end else if (bi == 0) begin
      sl_drv = 1'b0;
      if (reading) reading = 1'b0;
      else if (rd_next) begin
        reading = 1'b1; rd_next = 1'b0; sl_drv = ~srd[7];
      end
    end else if (reading) sl_drv = ~srd[7 - bi];
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg(input logic [3:0] m, input logic [31:0] d);
    @(negedge clk); be = m; wd = d; we = 1'b1;
    @(negedge clk); we = 1'b0; be = '0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (rd[24] && n < 5000) begin n++; @(negedge clk); end
  endtask

  initial begin
    #(CLK_P * 200000);
    nchk++; nerr++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    int n, nb, txs, rx, sr, q;
    logic [31:0] keep;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 reset word", rd, {4'b0001, 28'h0});
    chk("R9 reset lines", {30'h0, scl_pull, sda_pull}, 32'h0);

    romb = 1'b1; bok = 1'b0;
    @(negedge clk);
    chk("R1 status inputs", {30'h0, rd[29:28]}, 32'h2);
    cfg(4'b1000, 32'h4000_0000);
    chk("R1 test bit", {30'h0, rd[31:30]}, 32'h1);
    cfg(4'b0100, 32'h00A1_0000);
    chk("R3 rom busy blocks start", {31'h0, rd[24]}, 32'h0);
    repeat (8 * QD) @(negedge clk);
    chk("R3 rom busy no bus", {nstart, 1'b0, scl_pull}, 33'h0);
    romb = 1'b0; bok = 1'b1;

    cfg(4'b1011, 32'h0000_5A3C);
    chk("R2 no start without lane 2", {31'h0, rd[24]}, 32'h0);
    chk("R1 lane load", rd, {4'b0001, 4'h0, 8'hA1, 16'h5A3C});

    for (int i = 0; i < NV; i++) begin
      nlog = 0; nstart = 0; nstop = 0; mack = 1'b0;
      nack_at = (VT[i].nk == 4'hF) ? 99 : int'(VT[i].nk);
      srd = VT[i].s;
      cfg(4'b0011, {16'h0, VT[i].w, VT[i].d});
      cfg(4'b1000, {VT[i].q, 31'h0});
      cfg(4'b0100, {8'h0, VT[i].a, VT[i].r, 16'h0});
      chk("R2 busy after start", {30'h0, rd[25:24]}, 32'h1);
      chk("R7 error cleared at start", {31'h0, rd[25]}, 32'h0);
      wait_idle(n);
      q   = VT[i].q ? 1 : 3;
      txs = (nack_at < q) ? nack_at + 1 : q;
      rx  = (!VT[i].q && VT[i].r && nack_at >= q) ? 1 : 0;
      sr  = (!VT[i].q && VT[i].r && nack_at >= 2) ? 1 : 0;
      nb  = txs + rx;
      chk("R8 busy length", n, QD * (8 + 36 * nb + 4 * sr));
      chk("R7 error flag", {31'h0, rd[25]}, {31'h0, nack_at < q});
      chk("R4 byte count", nlog, txs);
      chk("R4 address byte", lg[0], {VT[i].a, VT[i].q ? VT[i].r : 1'b0});
      if (txs > 1) chk("R4 word address byte", lg[1], VT[i].w);
      if (txs > 2) chk(VT[i].r ? "R5 read address byte" : "R4 data byte",
                       lg[2], VT[i].r ? {VT[i].a, 1'b1} : VT[i].d);
      chk(VT[i].q ? "R6 data lane kept" : "R5 data lane", rd[7:0],
          rx ? VT[i].s : VT[i].d);
      chk("R5 start count", nstart, 1 + sr);
      chk("R7 stop count", nstop, 1);
      if (rx) chk("R5 master nack", {31'h0, mack}, 32'h1);
      chk("R1 quick select readback", {31'h0, rd[31]}, {31'h0, VT[i].q});
      chk("R9 idle lines", {30'h0, scl_pull, sda_pull}, 32'h0);
    end
    chk("R8 SCL high width", hi_w, 2 * QD);

    nstart = 0; nack_at = 99;
    cfg(4'b1111, 32'h00A0_3377);
    keep = rd;
    cfg(4'b0111, 32'h00FF_EEDD);
    wait_idle(n);
    chk("R3 writes ignored while busy", rd[23:0], keep[23:0]);
    chk("R3 single transfer", nstart, 1);

    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule